// File: doc/BRIEF.md
# Flash Bus Write Qualifier and Identification Front End

This block sits between the host bus pins of a small parallel NOR-style flash model and the model's command and array logic. It resynchronises the active-low chip-enable, output-enable and write-enable lines to the system clock. From these it decides when a real write cycle has taken place. For each accepted cycle it emits a one-cycle strobe that carries the address and data seen at the closing write-enable edge. A downstream command sequencer consumes that strobe.

Writes are refused in three cases: while the supply-low flag is set, during the first write-enable low phase after reset when the pins were already in a write posture, and for control pulses shorter than a parameterised number of clock cycles. The block keeps one protection bit per sector, indexed by the top three address bits. The program/erase engine asks the block whether a sector may be altered. While the high-voltage identification flag is set, reads return a manufacturer byte, a device byte or a sector's protection status, and the bitmap can be changed through a side-band port. Otherwise read data comes from the array input.

Top module: `flash_bus_front`

## Requirements
- R1: After reset, every sector reports `op_ok`=1 (unprotected), no `wr_stb` is issued, and with `id_hv` low `rdata` equals `array_rdata`.
- R2: With `ce_n`=0 and `oe_n`=1, if `we_n` stays low for at least `GLITCH_MIN` clock cycles and then rises while `ce_n` is still low, the block produces exactly one `wr_stb` pulse one cycle wide, with `wr_addr`/`wr_data` equal to `addr`/`wdata` at that rising edge.
- R3: A write-enable pulse while `oe_n`=0 or while `ce_n`=1 produces no `wr_stb`.
- R4: A write-enable low pulse shorter than `GLITCH_MIN` cycles produces no `wr_stb`.
- R5: While `supply_low`=1 no `wr_stb` is produced and `seq_clear`=1. Once the flag clears, a fresh full write cycle is accepted again.
- R6: If `ce_n`=0, `we_n`=0 and `oe_n`=1 when reset releases, the following `we_n` rise produces no strobe. The next complete write cycle is accepted.
- R7: With `id_hv`=1 and A6,A1,A0 = 0,0,0, `rdata` = 01h.
- R8: With `id_hv`=1 and A6,A1,A0 = 0,0,1, `rdata` = 20h.
- R9: With `id_hv`=1 and A6,A1,A0 = 0,1,0, `rdata` = 01h if the sector addressed by A16..A14 is protected and 00h otherwise.
- R10: With `id_hv`=1 and any other A6,A1,A0 combination, `rdata` = 00h.
- R11: `prot_we` writes `prot_val` into the bit of sector `prot_sect` only while `id_hv`=1, and is ignored otherwise. `op_ok` for `op_sect` is the inverse of that sector's bit, so a protected sector refuses program and erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Host address bus |
| wdata | input | DATA_W | Host write data |
| array_rdata | input | DATA_W | Read data from the array model |
| supply_low | input | 1 | Supply below lockout level |
| id_hv | input | 1 | High voltage present on the identification pin |
| prot_we | input | 1 | Side-band protection bit write |
| prot_sect | input | SECT_W | Sector selected for the side-band write |
| prot_val | input | 1 | 1 protects the sector, 0 unprotects it |
| op_sect | input | SECT_W | Sector targeted by a pending program/erase |
| rdata | output | DATA_W | Read data returned to the host |
| wr_stb | output | 1 | One-cycle accepted-write strobe |
| wr_addr | output | ADDR_W | Address captured with the strobe |
| wr_data | output | DATA_W | Data captured with the strobe |
| op_ok | output | 1 | 1 when `op_sect` may be programmed or erased |
| seq_clear | output | 1 | Forces the command sequencer back to read-array |

## Verification
The bench sweeps write pulses of widths on both sides of the glitch limit. A filter off by one either passes a two-cycle pulse or drops a three-cycle one. It raises write-enable with the pins already in write posture at reset release, which a design without the arming rule would take as a spurious command. It pulses write-enable under supply lockout and then checks that writing recovers. This exposes a lockout that leaks strobes or never releases. It also pokes the protection bitmap with the identification flag both low and high and reads it back through identification reads and `op_ok`. A side-band path that ignores the flag, or an index that picks the wrong sector, shows up as a wrong status byte.

// File: rtl/flash_bus_front_pkg.sv
package flash_bus_front_pkg;

   typedef enum logic [1:0] {
      IDS_MAKER  = 2'd0,
      IDS_DEVICE = 2'd1,
      IDS_LOCK   = 2'd2,
      IDS_ZERO   = 2'd3
   } id_sel_e;

   function automatic id_sel_e id_decode(input logic a6, input logic a1, input logic a0);
      id_sel_e r;
      case ({a6, a1, a0})
         3'b000:  r = IDS_MAKER;
         3'b001:  r = IDS_DEVICE;
         3'b010:  r = IDS_LOCK;
         default: r = IDS_ZERO;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/flash_bus_front_sync.sv
module flash_bus_front_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("sync WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/flash_bus_front_wqual.sv
module flash_bus_front_wqual #(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 8,
   parameter int GLITCH_MIN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_ce_n,
   input  logic              s_oe_n,
   input  logic              s_we_n,
   input  logic              s_low,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_data,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   localparam int CNT_W = $clog2(GLITCH_MIN + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(GLITCH_MIN);

   if (GLITCH_MIN < 1) begin : g_bad_glitch
      $error("GLITCH_MIN must be at least 1");
   end

   logic             armed_q;
   logic [CNT_W-1:0] run_q;
   logic             posture;
   logic             qualified;
   logic             close_ev;

   // write posture: chip selected, output disabled, write-enable low, supply good
   assign posture   = armed_q && !s_ce_n && s_oe_n && !s_we_n && !s_low;
   assign qualified = (run_q == CNT_TOP);
   // write closes on write-enable rise while still selected with outputs off
   assign close_ev  = qualified && s_we_n && !s_ce_n && s_oe_n && !s_low;

   // arming: a low write-enable phase counts only after write-enable has been seen high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        armed_q <= 1'b0;
      else if (s_low)    armed_q <= 1'b0;
      else if (s_we_n)   armed_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 run_q <= '0;
      else if (!posture)          run_q <= '0;
      else if (run_q != CNT_TOP)  run_q <= run_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= close_ev;
         if (close_ev) begin
            wr_addr <= s_addr;
            wr_data <= s_data;
         end
      end
   end

   // independent run-length monitor for the width assertion
   logic [CNT_W-1:0] mon_low_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     mon_low_q <= '0;
      else if (s_we_n)                mon_low_q <= '0;
      else if (mon_low_q != CNT_TOP)  mon_low_q <= mon_low_q + 1'b1;
   end

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
   a_r4_min_width: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> ($past(mon_low_q) == CNT_TOP));
   a_r5_no_strobe_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !$past(s_low));
   a_r6_needs_arming: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(armed_q));

endmodule

// File: rtl/flash_bus_front_prot.sv
module flash_bus_front_prot
   import flash_bus_front_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8,
   parameter int SECT_W = 3,
   parameter logic [DATA_W-1:0] MAKER_CODE  = 8'h01,
   parameter logic [DATA_W-1:0] DEVICE_CODE = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              id_act,
   input  logic              prot_we,
   input  logic [SECT_W-1:0] prot_sect,
   input  logic              prot_val,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] array_rdata,
   input  logic [SECT_W-1:0] op_sect,
   output logic [DATA_W-1:0] rdata,
   output logic              op_ok
);

   localparam int NSECT = 1 << SECT_W;

   if (ADDR_W < SECT_W + 7) begin : g_bad_addr
      $error("ADDR_W too small for sector field and identification bits");
   end

   logic [NSECT-1:0] lock_q;

   for (genvar s = 0; s < NSECT; s++) begin : g_sect
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lock_q[s] <= 1'b0;
         else if (id_act && prot_we && (prot_sect == SECT_W'(s)))
            lock_q[s] <= prot_val;
      end
   end

   logic [SECT_W-1:0] rd_sect;
   id_sel_e           sel;

   assign rd_sect = rd_addr[ADDR_W-1 -: SECT_W];
   assign sel     = id_decode(rd_addr[6], rd_addr[1], rd_addr[0]);
   assign op_ok   = !lock_q[op_sect];

   always_comb begin
      if (!id_act) begin
         rdata = array_rdata;
      end else begin
         unique case (sel)
            IDS_MAKER:  rdata = MAKER_CODE;
            IDS_DEVICE: rdata = DEVICE_CODE;
            IDS_LOCK:   rdata = DATA_W'(lock_q[rd_sect]);
            default:    rdata = '0;
         endcase
      end
   end

   a_r11_locked_without_id: assert property (@(posedge clk) disable iff (!rst_n)
      !id_act |=> $stable(lock_q));
   a_r9_status_is_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (id_act && sel == IDS_LOCK) |-> (rdata[DATA_W-1:1] == '0));

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front #(
   parameter int ADDR_W      = 17,
   parameter int DATA_W      = 8,
   parameter int SECT_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int GLITCH_MIN  = 3,
   parameter logic [DATA_W-1:0] MAKER_CODE  = 8'h01,
   parameter logic [DATA_W-1:0] DEVICE_CODE = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] array_rdata,
   input  logic              supply_low,
   input  logic              id_hv,
   input  logic              prot_we,
   input  logic [SECT_W-1:0] prot_sect,
   input  logic              prot_val,
   input  logic [SECT_W-1:0] op_sect,
   output logic [DATA_W-1:0] rdata,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              op_ok,
   output logic              seq_clear
);

   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must hold the identification bytes");
   end

   // control bundle: {supply_low, id_hv, oe_n, ce_n, we_n}
   // reset values keep the pins looking like a write posture with supply low,
   // so nothing is accepted until real levels have propagated
   localparam int CTL_W = 5;
   localparam logic [CTL_W-1:0] CTL_RST = 5'b1_0_1_0_0;
   localparam int BUS_W = ADDR_W + DATA_W;

   logic [CTL_W-1:0]  ctl_s;
   logic [BUS_W-1:0]  bus_s;

   flash_bus_front_sync #(
      .WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)
   ) u_sync_ctl (
      .clk(clk), .rst_n(rst_n),
      .d({supply_low, id_hv, oe_n, ce_n, we_n}),
      .q(ctl_s)
   );

   flash_bus_front_sync #(
      .WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)
   ) u_sync_bus (
      .clk(clk), .rst_n(rst_n),
      .d({addr, wdata}),
      .q(bus_s)
   );

   logic s_low, s_id, s_oe_n, s_ce_n, s_we_n;
   assign {s_low, s_id, s_oe_n, s_ce_n, s_we_n} = ctl_s;
   assign seq_clear = s_low;

   flash_bus_front_wqual #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_MIN(GLITCH_MIN)
   ) u_wqual (
      .clk(clk), .rst_n(rst_n),
      .s_ce_n(s_ce_n), .s_oe_n(s_oe_n), .s_we_n(s_we_n), .s_low(s_low),
      .s_addr(bus_s[BUS_W-1 -: ADDR_W]), .s_data(bus_s[DATA_W-1:0]),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   flash_bus_front_prot #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
      .MAKER_CODE(MAKER_CODE), .DEVICE_CODE(DEVICE_CODE)
   ) u_prot (
      .clk(clk), .rst_n(rst_n),
      .id_act(s_id),
      .prot_we(prot_we), .prot_sect(prot_sect), .prot_val(prot_val),
      .rd_addr(addr), .array_rdata(array_rdata), .op_sect(op_sect),
      .rdata(rdata), .op_ok(op_ok)
   );

   a_r5_clear_tracks_lockout: assert property (@(posedge clk) disable iff (!rst_n)
      seq_clear |-> !wr_stb);

endmodule

// File: tb/flash_bus_front_tb_top.sv
module flash_bus_front_tb_top;

   localparam int ADDR_W = 17;
   localparam int DATA_W = 8;
   localparam int SECT_W = 3;
   localparam int GMIN   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0, array_rdata = 8'h5A;
   logic supply_low = 1'b0, id_hv = 1'b0;
   logic prot_we = 1'b0, prot_val = 1'b0;
   logic [SECT_W-1:0] prot_sect = '0, op_sect = '0;
   logic [DATA_W-1:0] rdata;
   logic wr_stb, op_ok, seq_clear;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;

   int checks = 0, failures = 0;
   int stb_cnt = 0;
   logic [ADDR_W-1:0] last_addr = '0;
   logic [DATA_W-1:0] last_data = '0;
   bit finished = 0;

   always #2 clk = ~clk;

   flash_bus_front dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .wdata(wdata), .array_rdata(array_rdata),
      .supply_low(supply_low), .id_hv(id_hv),
      .prot_we(prot_we), .prot_sect(prot_sect), .prot_val(prot_val),
      .op_sect(op_sect), .rdata(rdata), .wr_stb(wr_stb),
      .wr_addr(wr_addr), .wr_data(wr_data), .op_ok(op_ok), .seq_clear(seq_clear)
   );

   always @(negedge clk) begin
      if (wr_stb) begin
         stb_cnt   <= stb_cnt + 1;
         last_addr <= wr_addr;
         last_data <= wr_data;
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input int low, input logic ce, input logic oe);
      addr = a; wdata = d; ce_n = ce; oe_n = oe;
      tick(2);
      we_n = 1'b0;
      tick(low);
      we_n = 1'b1;
      tick(3);
      ce_n = 1'b1; oe_n = 1'b1;
      tick(5);
   endtask

   // {addr[16:0], data[7:0], low_cycles[3:0], ce_n, oe_n, expect_strobe}
   localparam int NVEC = 7;
   localparam logic [31:0] VEC [NVEC] = '{
      {17'h1ABCD, 8'h3C, 4'd5, 1'b0, 1'b1, 1'b1},   // R2 long pulse
      {17'h00055, 8'hA5, 4'd3, 1'b0, 1'b1, 1'b1},   // R2/R4 exactly minimum
      {17'h00AAA, 8'h11, 4'd2, 1'b0, 1'b1, 1'b0},   // R4 one short
      {17'h00AAA, 8'h22, 4'd1, 1'b0, 1'b1, 1'b0},   // R4 single cycle
      {17'h05555, 8'h77, 4'd6, 1'b0, 1'b0, 1'b0},   // R3 output enabled
      {17'h05555, 8'h88, 4'd6, 1'b1, 1'b1, 1'b0},   // R3 chip deselected
      {17'h0F0F0, 8'hE1, 4'd4, 1'b0, 1'b1, 1'b1}    // R2 another pattern
   };

   initial begin
      #(4 * 100000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int base;
      // R6: pins in write posture across reset release
      tick(4);
      rst_n = 1'b1;
      tick(6);
      // R1 reset state
      check("R1 no strobe", stb_cnt, 0);
      check("R1 passthrough", rdata, 8'h5A);
      for (int s = 0; s < 8; s++) begin
         op_sect = SECT_W'(s); #1;
         check("R1 sector unprotected", op_ok, 1);
      end
      we_n = 1'b1;
      tick(8);
      check("R6 no command after power-up", stb_cnt, 0);
      ce_n = 1'b1;
      tick(2);
      bus_write(17'h00123, 8'h9E, 4, 1'b0, 1'b1);
      check("R6 next cycle accepted", stb_cnt, 1);

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         logic [31:0] v;
         v = VEC[i];
         base = stb_cnt;
         bus_write(v[31:15], v[14:7], int'(v[6:3]), v[2], v[1]);
         check("R2/R3/R4 strobe count", stb_cnt - base, int'(v[0]));
         if (v[0]) begin
            check("R2 latched address", last_addr, v[31:15]);
            check("R2 latched data", last_data, v[14:7]);
         end
      end

      // R5 supply lockout
      supply_low = 1'b1;
      tick(4);
      check("R5 seq_clear asserted", seq_clear, 1);
      base = stb_cnt;
      bus_write(17'h00321, 8'h44, 6, 1'b0, 1'b1);
      check("R5 no strobe during lockout", stb_cnt - base, 0);
      supply_low = 1'b0;
      tick(4);
      check("R5 seq_clear released", seq_clear, 0);
      bus_write(17'h00321, 8'h45, 4, 1'b0, 1'b1);
      check("R5 write after recovery", stb_cnt - base, 1);
      check("R5 recovered data", last_data, 8'h45);

      // R11: side-band ignored without identification flag
      prot_sect = 3'd5; prot_val = 1'b1; prot_we = 1'b1;
      tick(1);
      prot_we = 1'b0;
      op_sect = 3'd5; #1;
      check("R11 write ignored without id", op_ok, 1);

      // identification mode
      id_hv = 1'b1;
      tick(4);
      addr = 17'h00000; #1;
      check("R7 maker code", rdata, 8'h01);
      addr = 17'h1FF80 & ~17'h00043 | 17'h00001; #1;
      check("R8 device code", rdata, 8'h20);
      addr = {3'd5, 14'h0002}; #1;
      check("R9 unprotected status", rdata, 8'h00);
      addr = 17'h00040; #1;
      check("R10 A6 set", rdata, 8'h00);
      addr = 17'h00003; #1;
      check("R10 A1 A0 set", rdata, 8'h00);

      prot_sect = 3'd5; prot_val = 1'b1; prot_we = 1'b1;
      tick(1);
      prot_we = 1'b0;
      addr = {3'd5, 14'h0002}; #1;
      check("R9 protected status", rdata, 8'h01);
      addr = {3'd4, 14'h0002}; #1;
      check("R9 neighbour unprotected", rdata, 8'h00);
      op_sect = 3'd5; #1;
      check("R11 protected sector refused", op_ok, 0);
      op_sect = 3'd4; #1;
      check("R11 other sector allowed", op_ok, 1);

      prot_sect = 3'd5; prot_val = 1'b0; prot_we = 1'b1;
      tick(1);
      prot_we = 1'b0;
      op_sect = 3'd5; #1;
      check("R11 unprotect restores", op_ok, 1);

      id_hv = 1'b0;
      tick(4);
      array_rdata = 8'hC3; addr = 17'h00000; #1;
      check("R10 array passthrough", rdata, 8'hC3);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule